// File: doc/BRIEF.md
# Open-Row DRAM Word Controller

This block sits between a processor-side request port and a rank of byte-wide DRAM devices that are driven in lockstep to form one wide word. A request carries a word address, a direction and, for writes, the write word. The controller splits the address into a row index (upper bits) and a column index (lower bits). On the memory side it issues one command per cycle (precharge, activate, column access or refresh) on a shared, multiplexed address bus. Every device receives the same row and column coordinate, and each device owns one byte lane of the word.

The controller leaves the last activated row open. A request to that row needs only a column access. A request to a different row first closes the open row, then activates the new one, then issues the column access. Row-hit and row-miss counters show how often each path was taken.

An internal timer raises a refresh demand at a fixed spacing, which is derived from a refresh window and the number of rows. A pending demand blocks new requests, closes any open row, and issues a refresh that carries a rotating row index. Traffic then resumes from a closed row.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1; `rsp_valid`, `wr_ack` and all four memory command strobes are 0; both counters read 0.
- R2: The column index is `req_addr[COL_W-1:0]` and the row index is `req_addr[ROW_W+COL_W-1:COL_W]`. During an activate, `mem_addr` carries the row. During a column access, `mem_addr` carries the column.
- R3: If a request targets the row that is currently open, it is served by a single column access, with no precharge and no activate, and `hit_count` increases by one.
- R4: If a request targets a row other than the open one, the controller issues a precharge, an activate and a column access in three consecutive cycles, and `miss_count` increases by one.
- R5: If no row is open, a request is served by an activate followed by a column access in the next cycle, and is counted as a miss.
- R6: Byte lane k (bits 8k+7 down to 8k) of `mem_wdata` goes to device k, and read word lane k comes from `mem_rdata` bits 8k+7 down to 8k. All devices share one address and one set of strobes.
- R7: For a read, `rsp_valid` is high for exactly one cycle, two cycles after the read column access. `rsp_rdata` carries the word present on `mem_rdata` in the cycle after that column access.
- R8: For a write, `wr_ack` is high for exactly one cycle, in the cycle after the write column access (`mem_cas` with `mem_we` high).
- R9: Refresh commands come no more than REF_WINDOW_CYC/2^ROW_W + 8 cycles apart. A refresh is never issued while a row is open: an open row is precharged first. During a refresh, `mem_addr` carries a row index that starts at 0 and rises by one with each refresh, wrapping at 2^ROW_W.
- R10: While a refresh is pending, `req_ready` stays 0. A waiting request is accepted after the refresh and is served as a closed-row miss.
- R11: At most one of `mem_pre`, `mem_act`, `mem_cas` and `mem_ref` is high in any cycle. `req_ready` is 0 while a request or a refresh is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row above column |
| req_wdata | input | LANES*LANE_W | Write word |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | LANES*LANE_W | Read word |
| wr_ack | output | 1 | One-cycle write completion pulse |
| hit_count | output | CNT_W | Requests served on the open row |
| miss_count | output | CNT_W | Requests that needed an activate |
| mem_pre | output | 1 | Close open row |
| mem_act | output | 1 | Row access strobe |
| mem_cas | output | 1 | Column access strobe |
| mem_we | output | 1 | Column access is a write |
| mem_ref | output | 1 | Refresh command |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row / column / refresh row |
| mem_wdata | output | LANES*LANE_W | Byte lanes to the devices |
| mem_rdata | input | LANES*LANE_W | Byte lanes from the devices, valid the cycle after a read column access |

## Verification
A corrupted open-row register shows up at the ports within one request. A missing precharge, or a column access issued to the wrong row, changes the command count the bench expects for that request. The hit and miss counters drift from the bench's own tally. Reads return stale words. A wrong address split or lane swap puts bytes in the wrong device, and the write that does so is reported. The later read of that location then shows the same error. A stuck or late refresh timer is caught as soon as the spacing between refresh commands passes its bound, or when a refresh row index is skipped.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_CAS,
        ST_RDCAP,
        ST_RPRE,
        ST_REF
    } ctl_state_e;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 64,
    parameter int ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_done,
    output logic             ref_due,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             due;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.cnt == CW'(INTERVAL - 1));
        d.cnt = wrap ? '0 : q.cnt + 1'b1;
        if (ref_done) begin
            d.due = 1'b0;
            d.row = q.row + 1'b1;
        end
        if (wrap) d.due = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ref_due = q.due;
    assign ref_row = q.row;

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> (ref_row == $past(ref_row) + 1'b1)) else $error("refresh row index did not advance"); // R9

endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
    parameter int ROW_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             close,
    input  logic [ROW_W-1:0] act_row,
    input  logic [ROW_W-1:0] lookup_row,
    input  logic             count_hit,
    input  logic             count_miss,
    output logic             row_open,
    output logic             row_hit,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (close) d.open = 1'b0;
        if (act) begin
            d.open = 1'b1;
            d.row  = act_row;
        end
        if (count_hit)  d.hits   = q.hits + 1'b1;
        if (count_miss) d.misses = q.misses + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign row_open   = q.open;
    assign row_hit    = q.open && (q.row == lookup_row);
    assign hit_count  = q.hits;
    assign miss_count = q.misses;

    AST_NO_DOUBLE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> !row_open) else $error("activate while a row is open"); // R4
    AST_ONE_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(count_hit && count_miss)) else $error("request counted twice"); // R3

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W          = 4,
    parameter int COL_W          = 3,
    parameter int LANES          = 8,
    parameter int LANE_W         = 8,
    parameter int REF_WINDOW_CYC = 3_200_000,
    parameter int CNT_W          = 16,
    localparam int ADDR_W        = ROW_W + COL_W,
    localparam int WORD_W        = LANES * LANE_W,
    localparam int MA_W          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              wr_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic              mem_pre,
    output logic              mem_act,
    output logic              mem_cas,
    output logic              mem_we,
    output logic              mem_ref,
    output logic [MA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int ROWS        = 1 << ROW_W;
    localparam int REF_SPACING = (REF_WINDOW_CYC / ROWS > 1) ? REF_WINDOW_CYC / ROWS : 2;
    localparam int AGE_W       = 4;

    typedef struct packed {
        ctl_state_e        state;
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic              rsp_valid;
        logic              wr_ack;
        logic [AGE_W-1:0]  due_age;
    } ctl_t;

    ctl_t q, d;

    logic             ref_due;
    logic [ROW_W-1:0] ref_row;
    logic             row_open;
    logic             row_hit;
    logic             accept;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [WORD_W-1:0] rd_word;
    logic             lane_drive;

    assign req_col = req_addr[COL_W-1:0];
    assign req_row = req_addr[ADDR_W-1:COL_W];

    dram_refresh_timer #(
        .INTERVAL (REF_SPACING),
        .ROW_W    (ROW_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_done (q.state == ST_REF),
        .ref_due  (ref_due),
        .ref_row  (ref_row)
    );

    dram_row_tracker #(
        .ROW_W (ROW_W),
        .CNT_W (CNT_W)
    ) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (mem_act),
        .close      (mem_pre || mem_ref),
        .act_row    (q.row),
        .lookup_row (req_row),
        .count_hit  (accept && row_hit),
        .count_miss (accept && !row_hit),
        .row_open   (row_open),
        .row_hit    (row_hit),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // byte lanes: device k owns bits k*LANE_W +: LANE_W
    assign lane_drive = (q.state == ST_CAS) && q.wr;
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign mem_wdata[k*LANE_W +: LANE_W] = lane_drive ? q.wdata[k*LANE_W +: LANE_W] : '0;
        assign rd_word[k*LANE_W +: LANE_W]   = mem_rdata[k*LANE_W +: LANE_W];
    end

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.wr_ack    = 1'b0;
        accept      = 1'b0;
        d.due_age   = (ref_due && q.due_age != '1) ? q.due_age + 1'b1 : (ref_due ? q.due_age : '0);
        unique case (q.state)
            ST_IDLE: begin
                if (ref_due) begin
                    d.state = row_open ? ST_RPRE : ST_REF;
                end else if (req_valid) begin
                    accept  = 1'b1;
                    d.wr    = req_write;
                    d.row   = req_row;
                    d.col   = req_col;
                    d.wdata = req_wdata;
                    if (row_hit)       d.state = ST_CAS;
                    else if (row_open) d.state = ST_PRE;
                    else               d.state = ST_ACT;
                end
            end
            ST_PRE:  d.state = ST_ACT;
            ST_ACT:  d.state = ST_CAS;
            ST_CAS: begin
                if (q.wr) begin
                    d.wr_ack = 1'b1;
                    d.state  = ST_IDLE;
                end else begin
                    d.state  = ST_RDCAP;
                end
            end
            ST_RDCAP: begin
                d.rdata     = rd_word;
                d.rsp_valid = 1'b1;
                d.state     = ST_IDLE;
            end
            ST_RPRE: d.state = ST_REF;
            ST_REF:  d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.state == ST_IDLE) && !ref_due;
    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rdata;
    assign wr_ack    = q.wr_ack;
    assign mem_pre   = (q.state == ST_PRE) || (q.state == ST_RPRE);
    assign mem_act   = (q.state == ST_ACT);
    assign mem_cas   = (q.state == ST_CAS);
    assign mem_we    = (q.state == ST_CAS) && q.wr;
    assign mem_ref   = (q.state == ST_REF);

    always_comb begin
        unique case (q.state)
            ST_ACT:  mem_addr = MA_W'(q.row);
            ST_CAS:  mem_addr = MA_W'(q.col);
            ST_REF:  mem_addr = MA_W'(ref_row);
            default: mem_addr = '0;
        endcase
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_pre, mem_act, mem_cas, mem_ref})) else $error("two commands in one cycle"); // R11
    AST_PRE_THEN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pre |=> (mem_act || mem_ref)) else $error("precharge not followed by activate or refresh"); // R4
    AST_ACT_THEN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_act |=> mem_cas) else $error("activate not followed by column access"); // R5
    AST_CAS_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cas |-> row_open) else $error("column access with no open row"); // R3
    AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cas && !mem_we) |=> ##1 rsp_valid) else $error("read response late"); // R7
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("read pulse too long"); // R7
    AST_WR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cas && mem_we) |=> wr_ack) else $error("write ack missing"); // R8
    AST_REF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ref |-> !row_open) else $error("refresh with open row"); // R9
    AST_REF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_due |-> !req_ready) else $error("request accepted over pending refresh"); // R10
    AST_REF_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        q.due_age <= AGE_W'(8)) else $error("refresh waited too long"); // R9

endmodule

// File: tb/dram_ctrl_bench.sv
module dram_ctrl_bench;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int WORD_W = 64;
    localparam int WIN    = 1024;
    localparam int SPACE  = WIN / (1 << ROW_W);
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, wr_ack;
    logic [WORD_W-1:0] rsp_rdata, mem_wdata;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic [15:0] hit_count, miss_count;
    logic mem_pre, mem_act, mem_cas, mem_we, mem_ref;
    logic [3:0] mem_addr;

    always #10 clk = ~clk;

    dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .REF_WINDOW_CYC(WIN)) u_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_ack(wr_ack),
        .hit_count(hit_count), .miss_count(miss_count),
        .mem_pre(mem_pre), .mem_act(mem_act), .mem_cas(mem_cas), .mem_we(mem_we),
        .mem_ref(mem_ref), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // device model and bench-side expectations
    logic [7:0]  dev [8][DEPTH];
    logic [63:0] shadow [DEPTH];
    logic [ROW_W-1:0] dram_row = '0;
    bit model_open = 0;
    logic [ROW_W-1:0] model_row = '0;
    int exp_hits = 0, exp_misses = 0;
    logic [ROW_W-1:0] cur_row = '0;
    logic [COL_W-1:0] cur_col = '0;
    logic [63:0] cur_data = '0;
    int cnt_pre = 0, cnt_act = 0, cnt_cas = 0;
    int cyc = 0, cas_cyc = 0, since_ref = 0, ref_seen = 0, stalls = 0;
    logic [ROW_W-1:0] ref_idx = '0;
    bit gap_bad = 0;

    function automatic int predict_kind(bit open, logic [ROW_W-1:0] orow, logic [ROW_W-1:0] nrow);
        if (open && orow == nrow) return 0;
        return open ? 2 : 1;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            since_ref++;
            if (since_ref > SPACE + 8) gap_bad = 1;
            if (mem_ref) begin
                chk(mem_addr == MA(ref_idx), "R9 refresh row index", 64'(mem_addr), 64'(ref_idx));
                chk(req_ready == 1'b0, "R10 ready low during refresh", 64'(req_ready), 64'd0);
                ref_idx = ref_idx + 1'b1;
                ref_seen++;
                since_ref = 0;
                model_open = 0;
                if (req_valid) stalls++;
            end
            if (mem_pre) cnt_pre++;
            if (mem_act) begin
                cnt_act++;
                dram_row = mem_addr[ROW_W-1:0];
                chk(mem_addr == MA(cur_row), "R2 row on activate", 64'(mem_addr), 64'(cur_row));
            end
            if (mem_cas) begin
                cnt_cas++;
                cas_cyc = cyc;
                chk(mem_addr == MA(cur_col), "R2 column on column access", 64'(mem_addr), 64'(cur_col));
                if (mem_we) begin
                    for (int k = 0; k < 8; k++) dev[k][{dram_row, mem_addr[COL_W-1:0]}] = mem_wdata[8*k +: 8];
                    begin
                        logic [63:0] got;
                        for (int k = 0; k < 8; k++) got[8*k +: 8] = dev[k][{cur_row, cur_col}];
                        chk(got == cur_data, "R6 byte lanes reach their devices", got, cur_data);
                    end
                end else begin
                    for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = dev[k][{dram_row, mem_addr[COL_W-1:0]}];
                end
            end
            if (rsp_valid) chk(cyc - cas_cyc == 2, "R7 read response timing", 64'(cyc - cas_cyc), 64'd2);
            if (wr_ack)    chk(cyc - cas_cyc == 1, "R8 write ack timing", 64'(cyc - cas_cyc), 64'd1);
        end
    end

    function automatic logic [3:0] MA(input logic [3:0] v);
        return v;
    endfunction

    task automatic do_req(input bit wr, input logic [ADDR_W-1:0] a, input logic [63:0] dat);
        int kind, guard;
        @(negedge clk);
        cur_row = a[ADDR_W-1:COL_W];
        cur_col = a[COL_W-1:0];
        cur_data = dat;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        kind = predict_kind(model_open, model_row, cur_row);
        cnt_pre = 0; cnt_act = 0; cnt_cas = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 ready low while busy", 64'(req_ready), 64'd0);
        guard = 0;
        while (!(wr ? wr_ack : rsp_valid) && guard < 100) begin @(negedge clk); guard++; end
        chk(guard < 100, "R11 request completes", 64'(guard), 64'd0);
        model_open = 1; model_row = cur_row;
        if (kind == 0) exp_hits++; else exp_misses++;
        case (kind)
            0: chk(cnt_pre == 0 && cnt_act == 0 && cnt_cas == 1, "R3 hit uses column access only",
                   64'({cnt_pre[7:0], cnt_act[7:0], cnt_cas[7:0]}), 64'h000001);
            1: chk(cnt_pre == 0 && cnt_act == 1 && cnt_cas == 1, "R5 closed-row miss",
                   64'({cnt_pre[7:0], cnt_act[7:0], cnt_cas[7:0]}), 64'h000101);
            default: chk(cnt_pre == 1 && cnt_act == 1 && cnt_cas == 1, "R4 open-row miss",
                   64'({cnt_pre[7:0], cnt_act[7:0], cnt_cas[7:0]}), 64'h010101);
        endcase
        if (wr) shadow[a] = dat;
        else chk(rsp_rdata == shadow[a], "R7 R6 read data", rsp_rdata, shadow[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            shadow[i] = '0;
            for (int k = 0; k < 8; k++) dev[k][i] = '0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && wr_ack == 1'b0, "R1 reset handshake",
            64'({req_ready, rsp_valid, wr_ack}), 64'b100);
        chk({mem_pre, mem_act, mem_cas, mem_ref} == 4'b0, "R1 no command after reset",
            64'({mem_pre, mem_act, mem_cas, mem_ref}), 64'd0);
        chk(hit_count == 0 && miss_count == 0, "R1 counters cleared", 64'({hit_count, miss_count}), 64'd0);

        // directed: closed miss, hit, open miss, lane pattern
        do_req(1, 7'h2B, 64'h0807060504030201);
        do_req(0, 7'h2B, 64'd0);
        do_req(1, 7'h2C, 64'hF0E0D0C0B0A09080);
        do_req(0, 7'h51, 64'd0);
        do_req(0, 7'h2C, 64'd0);
        do_req(1, 7'h7F, 64'hFFFF_0000_AAAA_5555);
        do_req(0, 7'h00, 64'd0);
        do_req(0, 7'h7F, 64'd0);
        // idle across a refresh: next access starts from a closed row
        repeat (SPACE + 10) @(negedge clk);
        do_req(0, 7'h7E, 64'd0);

        // random traffic with row locality
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            a = {ROW_W'($urandom % 4), COL_W'($urandom)};
            if ($urandom % 8 == 0) a = ADDR_W'($urandom);
            do_req(($urandom % 2) == 1, a, {$urandom, $urandom});
            if ($urandom % 6 == 0) repeat ($urandom % 4) @(negedge clk);
        end
        for (int i = 0; i < DEPTH; i += 5) do_req(0, ADDR_W'(i), 64'd0);

        @(negedge clk);
        chk(hit_count == 16'(exp_hits), "R3 hit counter", 64'(hit_count), 64'(exp_hits));
        chk(miss_count == 16'(exp_misses), "R4 R5 miss counter", 64'(miss_count), 64'(exp_misses));
        chk(!gap_bad, "R9 refresh spacing bound", 64'(gap_bad), 64'd0);
        chk(ref_seen >= cyc / (SPACE + 8), "R9 refresh count", 64'(ref_seen), 64'(cyc / (SPACE + 8)));
        chk(stalls > 0, "R10 request held across refresh", 64'(stalls), 64'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule